// File: doc/BRIEF.md
# Scalar/Vector Memory Barrier Controller

This block holds a scalar core still while a memory barrier drains the vector memory unit. The core raises a one-cycle barrier request and marks it as either the ordinary barrier, which any program may use, or the privileged barrier, which only system code uses. Once the request is accepted the controller raises a stall and watches the vector side. The inputs are a count of vector memory instructions still in flight, a count of writes already issued but not yet visible, a flag that says a vector memory instruction has been suspended, the pending exception flags and a pending hardware-error flag.

The ordinary barrier ends in one of two ways. It completes when all vector memory work has drained. It faults when an unreported arithmetic or memory-management exception is pending. The privileged barrier never faults. It treats a suspended vector memory instruction as having stopped its memory activity. It still waits for every issued write to become visible and for any hardware error to be reported. On completion the controller writes a zero result word to the scalar destination for one cycle. On a fault it writes nothing, reports the fault class and returns to idle, so that the barrier can be issued again.

Top module: `vmem_barrier_ctrl`

## Requirements
- R1: After reset, stall, done, result_we and fault are all low.
- R2: A request seen while idle raises stall in the next cycle. Stall stays high up to and including the cycle with done or fault, and is low in the cycle after. A request made while stall is high is ignored, and so is the kind (req_priv) given with it.
- R3: When an ordinary barrier completes, done and result_we are high for exactly one cycle and result is zero.
- R4: An ordinary barrier that sees exc_arith high while stalled raises fault with fault_class 0 (vector unit disabled) and does not raise result_we.
- R5: When only exc_mm is high, fault_class is 1 (memory management). When both exception flags are high, fault_class is 0.
- R6: When the completion condition and a fault condition hold in the same cycle, fault is raised and done stays low.
- R7: A privileged barrier never raises fault, whatever the exception flags show, and completes while they are high.
- R8: A privileged barrier completes while vmem_outstanding is nonzero if vmem_suspended is high.
- R9: An ordinary barrier does not complete while vmem_outstanding is nonzero, even when vmem_suspended is high.
- R10: A privileged barrier does not complete while hwerr_pending is high.
- R11: After a fault the controller is idle, and a new barrier request is accepted and can complete.
- R12: Neither kind of barrier completes while wr_pending is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Barrier request pulse from the scalar core |
| req_priv | input | 1 | 1 = privileged barrier, 0 = ordinary barrier |
| vmem_outstanding | input | CNT_W | Vector memory instructions still in flight |
| wr_pending | input | CNT_W | Issued writes not yet visible |
| vmem_suspended | input | 1 | A vector memory instruction is suspended |
| exc_arith | input | 1 | Unreported vector arithmetic exception pending |
| exc_mm | input | 1 | Unreported memory-management exception pending |
| hwerr_pending | input | 1 | Vector hardware error not yet reported |
| stall | output | 1 | Scalar core must not issue instructions |
| done | output | 1 | Barrier completed this cycle |
| result | output | DATA_W | Result word for the scalar destination |
| result_we | output | 1 | Write enable for the scalar destination |
| fault | output | 1 | Ordinary barrier faulted this cycle |
| fault_class | output | 1 | 0 = vector unit disabled, 1 = memory management |

## Verification
Completion and fault can become true in the same cycle. This happens when the vector side is already drained and an exception is already pending at the moment the ordinary barrier is accepted. The bench sets up exactly that input state before issuing the barrier. In the first stalled cycle it expects fault high, done low and result_we low. It runs the same state again with a privileged request, where done must win because a privileged barrier cannot fault.

// File: rtl/vmb_pkg.sv
package vmb_pkg;

  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} vmb_state_e;

  typedef enum logic {FC_VUNIT_OFF = 1'b0, FC_MEM_MGMT = 1'b1} vmb_fclass_e;

  // Memory activity has stopped: nothing in flight, or (privileged only) the
  // in-flight instruction is parked in a suspended state.
  function automatic logic activity_ceased(input logic priv,
                                           input logic any_inflight,
                                           input logic suspended);
    return !any_inflight || (priv && suspended);
  endfunction

  // Arithmetic exceptions map to the vector-unit-disabled class and take
  // precedence over memory-management exceptions.
  function automatic vmb_fclass_e class_of(input logic arith, input logic mm);
    if (arith)   return FC_VUNIT_OFF;
    else if (mm) return FC_MEM_MGMT;
    else         return FC_VUNIT_OFF;
  endfunction

endpackage

// File: rtl/vmb_eval.sv
module vmb_eval
  import vmb_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             priv,
  input  logic [CNT_W-1:0] inflight,
  input  logic [CNT_W-1:0] writes_open,
  input  logic             suspended,
  input  logic             arith,
  input  logic             mm,
  input  logic             hwerr,
  output logic             ready_ok,
  output logic             fault_hit,
  output vmb_fclass_e      fclass
);

  logic any_inflight;
  logic writes_clear;

  assign any_inflight = |inflight;
  assign writes_clear = (writes_open == '0);

  always_comb begin
    ready_ok  = activity_ceased(priv, any_inflight, suspended) && writes_clear
                && !(priv && hwerr);
    fault_hit = !priv && (arith || mm);
    fclass    = class_of(arith, mm);
  end

endmodule

// File: rtl/vmb_fsm.sv
module vmb_fsm
  import vmb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_priv,
  input  logic finish,
  output logic busy,
  output logic priv_q
);

  vmb_state_e state_q, state_d;
  logic       priv_d;

  always_comb begin
    state_d = state_q;
    priv_d  = priv_q;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        state_d = ST_WAIT;
        priv_d  = req_priv;
      end
      ST_WAIT: if (finish) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      priv_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      priv_q  <= priv_d;
    end
  end

  assign busy = (state_q == ST_WAIT);

endmodule

// File: rtl/vmb_resp.sv
module vmb_resp
  import vmb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              busy,
  input  logic              ready_ok,
  input  logic              fault_hit,
  input  vmb_fclass_e       fclass_in,
  output logic              done,
  output logic              fault,
  output logic              fault_class,
  output logic              result_we,
  output logic [DATA_W-1:0] result
);

  always_comb begin
    fault       = busy && fault_hit;
    done        = busy && ready_ok && !fault_hit;
    result_we   = done;
    fault_class = fault ? logic'(fclass_in) : 1'b0;
    result      = '0;
  end

endmodule

// File: rtl/vmem_barrier_ctrl.sv
module vmem_barrier_ctrl
  import vmb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_priv,
  input  logic [CNT_W-1:0]  vmem_outstanding,
  input  logic [CNT_W-1:0]  wr_pending,
  input  logic              vmem_suspended,
  input  logic              exc_arith,
  input  logic              exc_mm,
  input  logic              hwerr_pending,
  output logic              stall,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              result_we,
  output logic              fault,
  output logic              fault_class
);

  logic        busy_w;
  logic        priv_w;
  logic        ready_w;
  logic        fault_hit_w;
  logic        finish_w;
  vmb_fclass_e fclass_w;

  vmb_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_priv  (req_priv),
    .finish    (finish_w),
    .busy      (busy_w),
    .priv_q    (priv_w)
  );

  vmb_eval #(.CNT_W(CNT_W)) u_eval (
    .priv        (priv_w),
    .inflight    (vmem_outstanding),
    .writes_open (wr_pending),
    .suspended   (vmem_suspended),
    .arith       (exc_arith),
    .mm          (exc_mm),
    .hwerr       (hwerr_pending),
    .ready_ok    (ready_w),
    .fault_hit   (fault_hit_w),
    .fclass      (fclass_w)
  );

  vmb_resp #(.DATA_W(DATA_W)) u_resp (
    .busy        (busy_w),
    .ready_ok    (ready_w),
    .fault_hit   (fault_hit_w),
    .fclass_in   (fclass_w),
    .done        (done),
    .fault       (fault),
    .fault_class (fault_class),
    .result_we   (result_we),
    .result      (result)
  );

  assign finish_w = done || fault;
  assign stall    = busy_w;

endmodule

// File: rtl/vmb_checker.sv
module vmb_checker #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             stall,
  input logic             done,
  input logic             result_we,
  input logic             fault,
  input logic             priv_w,
  input logic [CNT_W-1:0] wr_pending,
  input logic             hwerr_pending
);

  AST_STALL_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && req_valid) |=> stall); // R2

  AST_STALL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !stall); // R2

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    result_we |=> !result_we); // R3

  AST_WE_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    result_we |-> stall); // R3

  AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault)); // R6

  AST_PRIV_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !priv_w); // R7

  AST_PRIV_HWERR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && priv_w) |-> !hwerr_pending); // R10

  AST_WRITES_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_pending == '0)); // R12

endmodule

bind vmem_barrier_ctrl vmb_checker #(.CNT_W(CNT_W)) u_vmb_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .stall         (stall),
  .done          (done),
  .result_we     (result_we),
  .fault         (fault),
  .priv_w        (priv_w),
  .wr_pending    (wr_pending),
  .hwerr_pending (hwerr_pending)
);

// File: tb/tb_vmem_barrier_ctrl.sv
`timescale 1ns/1ps
module tb_vmem_barrier_ctrl;

  localparam int DATA_W = 32;
  localparam int CNT_W  = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_priv = 1'b0;
  logic [CNT_W-1:0]  vmem_outstanding = '0;
  logic [CNT_W-1:0]  wr_pending = '0;
  logic              vmem_suspended = 1'b0;
  logic              exc_arith = 1'b0;
  logic              exc_mm = 1'b0;
  logic              hwerr_pending = 1'b0;
  logic              stall, done, result_we, fault, fault_class;
  logic [DATA_W-1:0] result;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  vmem_barrier_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_priv(req_priv),
    .vmem_outstanding(vmem_outstanding), .wr_pending(wr_pending),
    .vmem_suspended(vmem_suspended), .exc_arith(exc_arith), .exc_mm(exc_mm),
    .hwerr_pending(hwerr_pending), .stall(stall), .done(done),
    .result(result), .result_we(result_we), .fault(fault),
    .fault_class(fault_class)
  );

  task automatic chk(input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_in();
    vmem_outstanding = '0; wr_pending = '0; vmem_suspended = 1'b0;
    exc_arith = 1'b0; exc_mm = 1'b0; hwerr_pending = 1'b0;
  endtask

  // Returns 1 ns after the negedge of the first stalled cycle.
  task automatic issue(input logic p);
    @(negedge clk); req_valid = 1'b1; req_priv = p;
    @(negedge clk); req_valid = 1'b0; req_priv = 1'b0; #1;
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R1", "stall", stall, 0);
    chk("R1", "done", done, 0);
    chk("R1", "result_we", result_we, 0);
    chk("R1", "fault", fault, 0);
  endtask

  task automatic t_plain_complete();
    clear_in(); vmem_outstanding = 2;
    issue(1'b0);
    chk("R2", "stall after request", stall, 1);
    chk("R2", "done while busy", done, 0);
    step(); vmem_outstanding = 0; wr_pending = 3; #1;
    chk("R12", "done with writes pending", done, 0);
    chk("R12", "stall with writes pending", stall, 1);
    wr_pending = 0; #1;
    chk("R3", "done", done, 1);
    chk("R3", "result_we", result_we, 1);
    chk("R3", "result", result, 0);
    chk("R2", "stall in done cycle", stall, 1);
    step();
    chk("R3", "result_we one cycle", result_we, 0);
    chk("R2", "stall released", stall, 0);
  endtask

  task automatic t_busy_ignore_and_suspend();
    clear_in(); vmem_outstanding = 1;
    issue(1'b0);
    vmem_suspended = 1'b1;
    @(negedge clk); req_valid = 1'b1; req_priv = 1'b1;
    @(negedge clk); req_valid = 1'b0; req_priv = 1'b0; #1;
    chk("R9", "plain done with suspended inflight", done, 0);
    chk("R2", "kind of second request ignored", stall, 1);
    vmem_suspended = 1'b0; vmem_outstanding = 0; #1;
    chk("R3", "done after drain", done, 1);
    step();
    chk("R2", "idle after done", stall, 0);
  endtask

  task automatic t_faults();
    clear_in(); vmem_outstanding = 1;
    issue(1'b0);
    exc_arith = 1'b1; #1;
    chk("R4", "fault", fault, 1);
    chk("R4", "fault_class", fault_class, 0);
    chk("R4", "result_we on fault", result_we, 0);
    step();
    chk("R11", "idle after fault", stall, 0);
    clear_in(); vmem_outstanding = 1;
    issue(1'b0);
    exc_mm = 1'b1; #1;
    chk("R5", "mm fault", fault, 1);
    chk("R5", "mm fault_class", fault_class, 1);
    step();
    clear_in(); vmem_outstanding = 1;
    issue(1'b0);
    exc_mm = 1'b1; exc_arith = 1'b1; #1;
    chk("R5", "both flags fault_class", fault_class, 0);
    step();
  endtask

  task automatic t_same_cycle();
    clear_in(); exc_mm = 1'b1;
    issue(1'b0);
    chk("R6", "fault wins", fault, 1);
    chk("R6", "done suppressed", done, 0);
    chk("R6", "no write", result_we, 0);
    step();
    clear_in(); exc_mm = 1'b1; exc_arith = 1'b1;
    issue(1'b1);
    chk("R7", "privileged done despite exceptions", done, 1);
    chk("R7", "privileged fault", fault, 0);
    step();
  endtask

  task automatic t_priv_suspend();
    clear_in(); vmem_outstanding = 3; vmem_suspended = 1'b1; exc_mm = 1'b1;
    issue(1'b1);
    chk("R8", "privileged done with suspended", done, 1);
    chk("R8", "result_we", result_we, 1);
    chk("R7", "no fault", fault, 0);
    step();
    clear_in(); vmem_outstanding = 3; vmem_suspended = 1'b1; wr_pending = 1;
    issue(1'b1);
    chk("R12", "privileged waits for writes", done, 0);
    wr_pending = 0; #1;
    chk("R12", "privileged done after writes", done, 1);
    step();
  endtask

  task automatic t_priv_hwerr();
    clear_in(); hwerr_pending = 1'b1;
    issue(1'b1);
    chk("R10", "done with hw error pending", done, 0);
    step();
    chk("R10", "still stalled", stall, 1);
    hwerr_pending = 1'b0; #1;
    chk("R10", "done after hw error reported", done, 1);
    step();
  endtask

  task automatic t_reissue();
    clear_in(); vmem_outstanding = 2;
    issue(1'b0);
    exc_arith = 1'b1; #1;
    chk("R11", "first attempt faults", fault, 1);
    step();
    clear_in();
    issue(1'b0);
    chk("R11", "reissued barrier completes", done, 1);
    chk("R11", "reissued write", result_we, 1);
    step();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        #1; t_reset();
        rst_n = 1'b1;
        step(); t_reset();
        t_plain_complete();
        t_busy_ignore_and_suspend();
        t_faults();
        t_same_cycle();
        t_priv_suspend();
        t_priv_hwerr();
        t_reissue();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule